// File: doc/BRIEF.md
# Machine-level CSR write legalizer

This block holds a small set of machine-level control and status registers for a 64-bit hart, with a parameter that narrows it to 32 bits. Every write passes through a register-specific legalization step before it is stored. A field whose new value is not supported falls back to its previous content. Configuration bytes for the memory protection entries are merged one byte at a time, depending on whether the owning entry accepts the change. Clearing the compressed-instruction bit is refused when the next fetch address is not 8-byte aligned. A translation mode that is not supported is discarded.

The read port is combinational. It returns the legalized view of the selected register. That view includes the dirty-state summary bit of the status register, which is computed at read time, and the alignment masking of the two exception-PC registers. The surrounding pipeline supplies three inputs: the low bits of the next PC, the current privilege level, and a per-entry accept vector. The accept vector stands in for the lock check of the protection entries.

Top module: `csr_legalize_unit`

## Requirements
- R1: After reset: STATUS reads 0x0000000A_00002000 (FS in bits [14:13] = 01 Initial, UXL [33:32] = 2, SXL [35:34] = 2). MISA reads 0x80000000_0014112D (MXL [63:62] = 2, letter bits A0, C2, D3, F5, I8, M12, S18, U20). Both counter-enable registers read 0x7, TSELECT reads 1, the NMI-enable register reads 1, and every other register reads 0.
- R2: A SATP write whose mode field [63:60] is neither 0 (bare) nor 8 (Sv39) keeps the previous mode. The rest of the word is taken from the write. A legal mode is stored as written.
- R3: A TSELECT write stores the written value plus one, wrapping modulo 2^XLEN.
- R4: A MISA write with bit 2 (C) at 0 leaves C unchanged when next_pc_lo is not zero. The other bits are stored as written.
- R5: In 64-bit mode a STATUS write leaves bits [35:32] (SXL, UXL) unchanged. The other bits are stored as written.
- R6: A STATUS read returns the stored value with its top bit replaced by SD. SD is 1 when any of FS [14:13], XS [16:15] or VS [10:9] equals 3.
- R7: A MEPC or SEPC read returns bit 0 as 0. It also returns bit 1 as 0 when the stored MISA C bit is 0.
- R8: A PMP configuration write in machine mode updates each byte b of register k only if pmp_accept[b + 4*k] is 1. Otherwise the old byte is kept.
- R9: A PMP configuration write while priv is not 3 (machine) changes nothing and raises wr_illegal during the write cycle. wr_illegal is 0 for every other write.
- R10: Reads of index 0x10 to 0x1F return 0 with rd_illegal at 1, and rd_illegal is 0 below 0x10. The vendor, architecture and implementation IDs always read 0, and NMI enable always reads 1; writes to these four registers have no effect.
- R11: Index map: 0x00 STATUS, 0x01 MISA, 0x02 SATP, 0x03 TSELECT, 0x04 MEPC, 0x05 SEPC, 0x06 machine counter enable, 0x07 supervisor counter enable, 0x08 to 0x0A IDs, 0x0B NMI enable, 0x0C to 0x0F PMP configuration 0 to 3. The EPC and counter-enable registers store writes unchanged. A write takes effect at the clock edge and is visible on the read port from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Register index of the write |
| wr_data | input | XLEN | Raw write value |
| next_pc_lo | input | 3 | Low three bits of the next fetch PC |
| priv | input | 2 | Current privilege level, 3 = machine |
| pmp_accept | input | 4*3+XLEN/8 | Per-entry permission to change a config byte |
| rd_idx | input | 5 | Register index of the read |
| rd_data | output | XLEN | Legalized read value |
| rd_illegal | output | 1 | Read of an unimplemented index |
| wr_illegal | output | 1 | PMP configuration write outside machine mode |

## Verification
A wrong stored field becomes visible on the read port in the cycle after the write that should have set it, since reads are combinational from the registers. The bench therefore reads back every register directly after each write, and any legalization error in a mode, C bit or byte merge is caught within one cycle. A wrong SD or EPC mask shows up on that same read with no delay. A PMP write that is wrongly accepted outside machine mode corrupts a byte, and the corruption is seen on the following read of that register.

// File: rtl/csr_leg_pkg.sv
package csr_leg_pkg;
  localparam int IDX_W    = 5;
  localparam int PMP_REGS = 4;

  localparam logic [IDX_W-1:0] CSR_STATUS = 5'h00;
  localparam logic [IDX_W-1:0] CSR_MISA   = 5'h01;
  localparam logic [IDX_W-1:0] CSR_SATP   = 5'h02;
  localparam logic [IDX_W-1:0] CSR_TSEL   = 5'h03;
  localparam logic [IDX_W-1:0] CSR_MEPC   = 5'h04;
  localparam logic [IDX_W-1:0] CSR_SEPC   = 5'h05;
  localparam logic [IDX_W-1:0] CSR_MCNTEN = 5'h06;
  localparam logic [IDX_W-1:0] CSR_SCNTEN = 5'h07;
  localparam logic [IDX_W-1:0] CSR_VENDOR = 5'h08;
  localparam logic [IDX_W-1:0] CSR_ARCH   = 5'h09;
  localparam logic [IDX_W-1:0] CSR_IMPL   = 5'h0A;
  localparam logic [IDX_W-1:0] CSR_NMIEN  = 5'h0B;

  localparam logic [1:0] PRIV_M = 2'd3;

  // Translation mode: only bare (0) and Sv39 (8) are kept in 64-bit mode.
  function automatic logic [63:0] satp_legalize(logic [63:0] old_v, logic [63:0] new_v,
                                                logic is64);
    logic [63:0] r;
    r = new_v;
    if (is64 && (new_v[63:60] != 4'd0) && (new_v[63:60] != 4'd8))
      r[63:60] = old_v[63:60];
    return r;
  endfunction

  // Clearing C is refused unless the next fetch is 8-byte aligned.
  function automatic logic [63:0] misa_legalize(logic [63:0] old_v, logic [63:0] new_v,
                                                logic [2:0] npc_lo);
    logic [63:0] r;
    r = new_v;
    if (!new_v[2] && (npc_lo != 3'd0))
      r[2] = old_v[2];
    return r;
  endfunction

  // XLEN fields of the status register are fixed in 64-bit mode.
  function automatic logic [63:0] status_merge(logic [63:0] old_v, logic [63:0] new_v,
                                               logic is64);
    logic [63:0] r;
    r = new_v;
    if (is64)
      r[35:32] = old_v[35:32];
    return r;
  endfunction

  function automatic logic [63:0] status_view(logic [63:0] st, logic is64);
    logic [63:0] r;
    logic sd;
    sd = (&st[14:13]) | (&st[16:15]) | (&st[10:9]);
    r  = st;
    if (is64) r[63] = sd;
    else      r[31] = sd;
    return r;
  endfunction

  function automatic logic [63:0] epc_view(logic [63:0] v, logic c_on);
    logic [63:0] r;
    r    = v;
    r[0] = 1'b0;
    if (!c_on) r[1] = 1'b0;
    return r;
  endfunction

  function automatic logic [63:0] byte_merge(logic [63:0] old_v, logic [63:0] new_v,
                                             logic [7:0] take);
    logic [63:0] r;
    r = old_v;
    for (int b = 0; b < 8; b++)
      if (take[b]) r[8*b +: 8] = new_v[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/csr_scalar_regs.sv
module csr_scalar_regs
  import csr_leg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [2:0]       next_pc_lo,
  output logic [XLEN-1:0]  status_q,
  output logic [XLEN-1:0]  misa_q,
  output logic [XLEN-1:0]  satp_q,
  output logic [XLEN-1:0]  tsel_q,
  output logic [XLEN-1:0]  mepc_q,
  output logic [XLEN-1:0]  sepc_q,
  output logic [XLEN-1:0]  mcnt_q,
  output logic [XLEN-1:0]  scnt_q,
  output logic             satp_fallback,
  output logic             misa_c_refused
);
  localparam logic        IS64       = (XLEN == 64);
  localparam logic [63:0] LETTERS    = 64'h0000_0000_0014_112D;
  localparam logic [63:0] MISA_RST   = IS64 ? (LETTERS | (64'd2 << 62)) : (LETTERS | (64'd1 << 30));
  localparam logic [63:0] STATUS_RST = IS64 ? 64'h0000_000A_0000_2000 : 64'h0000_0000_0000_2000;

  logic [63:0] wd64;
  logic [63:0] status_ns, misa_ns, satp_ns;

  always_comb begin
    wd64      = 64'(wr_data);
    status_ns = status_merge(64'(status_q), wd64, IS64);
    misa_ns   = misa_legalize(64'(misa_q), wd64, next_pc_lo);
    satp_ns   = satp_legalize(64'(satp_q), wd64, IS64);
  end

  assign satp_fallback  = wr_en && (wr_idx == CSR_SATP) && (satp_ns != wd64);
  assign misa_c_refused = wr_en && (wr_idx == CSR_MISA) && (misa_ns != wd64);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= STATUS_RST[XLEN-1:0];
      misa_q   <= MISA_RST[XLEN-1:0];
      satp_q   <= '0;
      tsel_q   <= XLEN'(1);
      mepc_q   <= '0;
      sepc_q   <= '0;
      mcnt_q   <= XLEN'(7);
      scnt_q   <= XLEN'(7);
    end else if (wr_en) begin
      case (wr_idx)
        CSR_STATUS: status_q <= status_ns[XLEN-1:0];
        CSR_MISA:   misa_q   <= misa_ns[XLEN-1:0];
        CSR_SATP:   satp_q   <= satp_ns[XLEN-1:0];
        CSR_TSEL:   tsel_q   <= wr_data + XLEN'(1);
        CSR_MEPC:   mepc_q   <= wr_data;
        CSR_SEPC:   sepc_q   <= wr_data;
        CSR_MCNTEN: mcnt_q   <= wr_data;
        CSR_SCNTEN: scnt_q   <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/csr_pmp_bank.sv
module csr_pmp_bank
  import csr_leg_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NENT = 4 * (PMP_REGS - 1) + XLEN / 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_go,
  input  logic [1:0]               wr_sel,
  input  logic [XLEN-1:0]          wr_data,
  input  logic [NENT-1:0]          accept,
  output logic [PMP_REGS*XLEN-1:0] cfg_flat
);
  localparam int NB = XLEN / 8;

  for (genvar r = 0; r < PMP_REGS; r++) begin : g_reg
    logic [XLEN-1:0] q;
    logic [NB-1:0]   take;
    logic [63:0]     merged;

    assign take   = accept[4*r +: NB];
    assign merged = byte_merge(64'(q), 64'(wr_data), 8'(take));

    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= '0;
      else if (wr_go && (wr_sel == 2'(r)))
        q <= merged[XLEN-1:0];
    end

    assign cfg_flat[r*XLEN +: XLEN] = q;
  end
endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
  import csr_leg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [IDX_W-1:0]         rd_idx,
  input  logic [XLEN-1:0]          status_q,
  input  logic [XLEN-1:0]          misa_q,
  input  logic [XLEN-1:0]          satp_q,
  input  logic [XLEN-1:0]          tsel_q,
  input  logic [XLEN-1:0]          mepc_q,
  input  logic [XLEN-1:0]          sepc_q,
  input  logic [XLEN-1:0]          mcnt_q,
  input  logic [XLEN-1:0]          scnt_q,
  input  logic [PMP_REGS*XLEN-1:0] pmp_flat,
  output logic [XLEN-1:0]          rd_data,
  output logic                     rd_illegal
);
  localparam logic IS64 = (XLEN == 64);

  logic [63:0] st_view, mepc_view, sepc_view;

  always_comb begin
    st_view   = status_view(64'(status_q), IS64);
    mepc_view = epc_view(64'(mepc_q), misa_q[2]);
    sepc_view = epc_view(64'(sepc_q), misa_q[2]);
  end

  assign rd_illegal = rd_idx[4];

  always_comb begin
    rd_data = '0;
    if (!rd_idx[4]) begin
      case (rd_idx)
        CSR_STATUS: rd_data = st_view[XLEN-1:0];
        CSR_MISA:   rd_data = misa_q;
        CSR_SATP:   rd_data = satp_q;
        CSR_TSEL:   rd_data = tsel_q;
        CSR_MEPC:   rd_data = mepc_view[XLEN-1:0];
        CSR_SEPC:   rd_data = sepc_view[XLEN-1:0];
        CSR_MCNTEN: rd_data = mcnt_q;
        CSR_SCNTEN: rd_data = scnt_q;
        CSR_NMIEN:  rd_data = XLEN'(1);
        CSR_VENDOR, CSR_ARCH, CSR_IMPL: rd_data = '0;
        default:    rd_data = pmp_flat[rd_idx[1:0]*XLEN +: XLEN];
      endcase
    end
  end
endmodule

// File: rtl/csr_legalize_unit.sv
module csr_legalize_unit
  import csr_leg_pkg::*;
#(
  parameter  int XLEN = 64,
  localparam int NENT = 4 * (PMP_REGS - 1) + XLEN / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [2:0]       next_pc_lo,
  input  logic [1:0]       priv,
  input  logic [NENT-1:0]  pmp_accept,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data,
  output logic             rd_illegal,
  output logic             wr_illegal
);
  logic [XLEN-1:0] status_q, misa_q, satp_q, tsel_q;
  logic [XLEN-1:0] mepc_q, sepc_q, mcnt_q, scnt_q;
  logic [PMP_REGS*XLEN-1:0] pmp_flat;
  logic satp_fallback, misa_c_refused;
  logic pmp_hit, pmp_go;

  assign pmp_hit    = wr_en && (wr_idx[4:2] == 3'b011);
  assign pmp_go     = pmp_hit && (priv == PRIV_M);
  assign wr_illegal = pmp_hit && (priv != PRIV_M);

  csr_scalar_regs #(.XLEN(XLEN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .next_pc_lo(next_pc_lo),
    .status_q(status_q), .misa_q(misa_q), .satp_q(satp_q), .tsel_q(tsel_q),
    .mepc_q(mepc_q), .sepc_q(sepc_q), .mcnt_q(mcnt_q), .scnt_q(scnt_q),
    .satp_fallback(satp_fallback), .misa_c_refused(misa_c_refused)
  );

  csr_pmp_bank #(.XLEN(XLEN), .NENT(NENT)) u_pmp (
    .clk(clk), .rst_n(rst_n), .wr_go(pmp_go), .wr_sel(wr_idx[1:0]),
    .wr_data(wr_data), .accept(pmp_accept), .cfg_flat(pmp_flat)
  );

  csr_read_mux #(.XLEN(XLEN)) u_rd (
    .rd_idx(rd_idx),
    .status_q(status_q), .misa_q(misa_q), .satp_q(satp_q), .tsel_q(tsel_q),
    .mepc_q(mepc_q), .sepc_q(sepc_q), .mcnt_q(mcnt_q), .scnt_q(scnt_q),
    .pmp_flat(pmp_flat), .rd_data(rd_data), .rd_illegal(rd_illegal)
  );
endmodule

// File: rtl/csr_legalize_chk.sv
module csr_legalize_chk
  import csr_leg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [IDX_W-1:0]         wr_idx,
  input logic [XLEN-1:0]          wr_data,
  input logic [XLEN-1:0]          status_q,
  input logic [XLEN-1:0]          tsel_q,
  input logic [3:0]               satp_mode,
  input logic                     misa_c,
  input logic [PMP_REGS*XLEN-1:0] pmp_flat,
  input logic                     satp_fallback,
  input logic                     misa_c_refused,
  input logic                     wr_illegal,
  input logic [IDX_W-1:0]         rd_idx,
  input logic [XLEN-1:0]          rd_data,
  input logic                     rd_illegal
);
  // R3
  tsel_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == CSR_TSEL) |=> (tsel_q == $past(wr_data) + XLEN'(1)));

  // R2
  satp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    satp_fallback |=> $stable(satp_mode));

  // R4
  misa_c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misa_c_refused |=> $stable(misa_c));

  // R9
  pmp_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal |=> $stable(pmp_flat));

  // R10
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_illegal |-> (rd_data == '0));

  // R7
  epc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == CSR_MEPC || rd_idx == CSR_SEPC) |-> !rd_data[0]);

  if (XLEN == 64) begin : g_wide
    // R2
    satp_mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (satp_mode == 4'd0) || (satp_mode == 4'd8));

    // R5
    xl_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[35:32] == 4'hA);
  end
endmodule

bind csr_legalize_unit csr_legalize_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .status_q(status_q), .tsel_q(tsel_q), .satp_mode(satp_q[XLEN-1 -: 4]),
  .misa_c(misa_q[2]), .pmp_flat(pmp_flat), .satp_fallback(satp_fallback),
  .misa_c_refused(misa_c_refused), .wr_illegal(wr_illegal), .rd_idx(rd_idx),
  .rd_data(rd_data), .rd_illegal(rd_illegal)
);

// File: tb/tb_csr_legalize_unit.sv
module tb_csr_legalize_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [2:0]  next_pc_lo = '0;
  logic [1:0]  priv = 2'd3;
  logic [19:0] pmp_accept = '0;
  logic [4:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic        rd_illegal, wr_illegal;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [63:0] m_st, m_misa, m_satp, m_tsel, m_mepc, m_sepc, m_mc, m_sc;
  logic [63:0] m_pmp [4];

  always #10 clk = ~clk;

  csr_legalize_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .next_pc_lo(next_pc_lo), .priv(priv), .pmp_accept(pmp_accept),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_illegal(rd_illegal), .wr_illegal(wr_illegal)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic [4:0] i);
    if (i >= 5'h10) return "R10";
    case (i)
      5'h00: return "R5 R6";
      5'h01: return "R4";
      5'h02: return "R2";
      5'h03: return "R3";
      5'h04, 5'h05: return "R7 R11";
      5'h06, 5'h07: return "R11";
      5'h08, 5'h09, 5'h0A, 5'h0B: return "R10";
      default: return "R8 R9";
    endcase
  endfunction

  function automatic logic [63:0] model_read(logic [4:0] i);
    logic [63:0] v;
    logic dirty;
    case (i)
      5'h00: begin
        dirty = (m_st[14:13] == 2'b11) || (m_st[16:15] == 2'b11) || (m_st[10:9] == 2'b11);
        v = {dirty, m_st[62:0]};
      end
      5'h01: v = m_misa;
      5'h02: v = m_satp;
      5'h03: v = m_tsel;
      5'h04: v = m_mepc & (m_misa[2] ? ~64'h1 : ~64'h3);
      5'h05: v = m_sepc & (m_misa[2] ? ~64'h1 : ~64'h3);
      5'h06: v = m_mc;
      5'h07: v = m_sc;
      5'h0B: v = 64'd1;
      5'h0C, 5'h0D, 5'h0E, 5'h0F: v = m_pmp[i - 5'h0C];
      default: v = 64'd0;
    endcase
    return v;
  endfunction

  task automatic model_reset();
    m_st = 64'h0000_000A_0000_2000;
    m_misa = 64'h8000_0000_0014_112D;
    m_satp = 0; m_tsel = 1; m_mepc = 0; m_sepc = 0; m_mc = 7; m_sc = 7;
    for (int k = 0; k < 4; k++) m_pmp[k] = 0;
  endtask

  task automatic model_write(logic [4:0] i, logic [63:0] d, logic [1:0] p,
                             logic [19:0] acc, logic [2:0] npc);
    int k;
    case (i)
      5'h00: m_st = {d[63:36], m_st[35:32], d[31:0]};
      5'h01: m_misa = d | (((npc != 0) && !d[2]) ? (m_misa & 64'h4) : 64'h0);
      5'h02: m_satp = (d[63:60] == 4'h0 || d[63:60] == 4'h8) ? d : {m_satp[63:60], d[59:0]};
      5'h03: m_tsel = d + 64'd1;
      5'h04: m_mepc = d;
      5'h05: m_sepc = d;
      5'h06: m_mc = d;
      5'h07: m_sc = d;
      5'h0C, 5'h0D, 5'h0E, 5'h0F: if (p == 2'd3) begin
        k = int'(i) - 12;
        for (int b = 0; b < 8; b++)
          if (acc[b + 4*k]) m_pmp[k][8*b +: 8] = d[8*b +: 8];
      end
      default: ;
    endcase
  endtask

  task automatic do_write(logic [4:0] i, logic [63:0] d, logic [1:0] p,
                          logic [19:0] acc, logic [2:0] npc);
    logic exp_ill;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = d; priv = p; pmp_accept = acc; next_pc_lo = npc;
    #3;
    exp_ill = (i >= 5'h0C && i <= 5'h0F) && (p != 2'd3);
    check("R9 wr_illegal", 64'(wr_illegal), 64'(exp_ill));
    @(posedge clk);
    model_write(i, d, p, acc, npc);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [4:0] i);
    rd_idx = i;
    #2;
    check(tag_of(i), rd_data, model_read(i));
    check("R10 rd_illegal", 64'(rd_illegal), 64'(i >= 5'h10));
  endtask

  initial begin
    void'($urandom(32'd7));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset view of every implemented register plus one unimplemented
    for (int i = 0; i < 17; i++) begin
      rd_idx = 5'(i);
      #2;
      check("R1 reset", rd_data, model_read(5'(i)));
    end
    check("R1 misa", model_read(5'h01), 64'h8000_0000_0014_112D);

    // R2: unsupported mode keeps 0, Sv39 accepted, then unsupported keeps 8
    do_write(5'h02, 64'h5000_0000_0000_1234, 2'd3, '0, 3'd0); do_read(5'h02);
    check("R2 mode kept", rd_data, 64'h0000_0000_0000_1234);
    do_write(5'h02, 64'h8000_0000_0000_00AA, 2'd3, '0, 3'd0); do_read(5'h02);
    do_write(5'h02, 64'h9000_0000_0000_00BB, 2'd3, '0, 3'd0); do_read(5'h02);
    check("R2 mode 8 held", rd_data, 64'h8000_0000_0000_00BB);

    // R3: plus one, and wrap
    do_write(5'h03, 64'h10, 2'd3, '0, 3'd0); do_read(5'h03);
    check("R3 tsel", rd_data, 64'h11);
    do_write(5'h03, '1, 2'd3, '0, 3'd0); do_read(5'h03);
    check("R3 wrap", rd_data, 64'h0);

    // R4 and R7: refused clear of C, EPC masking with C on and off
    do_write(5'h04, 64'hFFFF_0000_0000_000F, 2'd3, '0, 3'd0);
    do_write(5'h01, 64'h8000_0000_0014_1129, 2'd3, '0, 3'd2); do_read(5'h01);
    check("R4 refused", rd_data, 64'h8000_0000_0014_112D);
    do_read(5'h04);
    check("R7 C on", rd_data, 64'hFFFF_0000_0000_000E);
    do_write(5'h01, 64'h8000_0000_0014_1129, 2'd3, '0, 3'd0); do_read(5'h01);
    check("R4 cleared", rd_data, 64'h8000_0000_0014_1129);
    do_read(5'h04);
    check("R7 C off", rd_data, 64'hFFFF_0000_0000_000C);

    // R5 and R6
    do_write(5'h00, '1, 2'd3, '0, 3'd0); do_read(5'h00);
    check("R5 xl fixed", rd_data, 64'hFFFF_FFFA_FFFF_FFFF);
    do_write(5'h00, 64'h8000_0000_0000_0000, 2'd3, '0, 3'd0); do_read(5'h00);
    check("R6 sd clean", rd_data, 64'h0000_000A_0000_0000);
    do_write(5'h00, 64'h0000_0000_0000_0600, 2'd3, '0, 3'd0); do_read(5'h00);
    check("R6 vs dirty", rd_data, 64'h8000_000A_0000_0600);

    // R8 and R9
    do_write(5'h0F, 64'h1122_3344_5566_7788, 2'd3, 20'h5_5000, 3'd0); do_read(5'h0F);
    check("R8 merge", rd_data, 64'h0022_0044_0066_0088);
    do_write(5'h0C, '1, 2'd1, '1, 3'd0); do_read(5'h0C);
    check("R9 ignored", rd_data, 64'h0);

    // R10: read-only and unimplemented
    do_write(5'h08, '1, 2'd3, '0, 3'd0); do_read(5'h08);
    do_write(5'h0B, 64'h0, 2'd3, '0, 3'd0); do_read(5'h0B);
    do_write(5'h15, '1, 2'd3, '0, 3'd0); do_read(5'h15);

    // Random mix
    for (int t = 0; t < 400; t++) begin
      logic [4:0] i;
      logic [63:0] d;
      i = 5'($urandom_range(0, 31));
      d = {$urandom(), $urandom()};
      if (($urandom() & 3) == 0) d[63:60] = 4'h8;
      do_write(i, d, 2'($urandom_range(0, 3) | (($urandom() & 1) ? 2'd3 : 2'd0)),
               20'($urandom()), 3'($urandom() & (($urandom() & 1) ? 32'd7 : 32'd0)));
      do_read(i);
      do_read(5'($urandom_range(0, 31)));
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule